// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a synchronous static memory whose data phase always trails its command by exactly two clock cycles. Because the lag is the same for reads and writes, a host can issue a read, a write, a read and so on in consecutive cycles. The shared data bus then changes direction with no idle cycle in between. Each word is 36 bits wide, split into four 9-bit byte lanes. A small internal array holds `2**ADDR_W` words.

Each command is a load or an advance. A load starts a new operation at the presented address, but only when all three chip selects are active. An advance steps a 4-word burst through linear or interleaved address order. A clock-enable input freezes the whole block. The tri-state data pad is split into an input bus, an output bus and an output-enable line, so the pad buffer stays outside the core. An asynchronous output-enable input can silence the outputs at any time.

The command decoder is a three-state machine:
- `ST_IDLE`: deselected.
- `ST_READ`: a read burst is active.
- `ST_WRITE`: a write burst is active.

Transitions:
- A load with all selects active goes to `ST_READ` when `rd_wr`=1 and to `ST_WRITE` when `rd_wr`=0.
- A load with any select inactive goes to `ST_IDLE`.
- An advance keeps the current state. In `ST_READ` or `ST_WRITE` it also issues the next burst address.

Top module: `zbt_sram`

## Requirements
- R1: A read issued at rising edge n drives its word on `dq_o` with `dq_oe`=1 in the cycle after edge n+1. This holds with no stall and with `out_en_n`=0.
- R2: A write issued at edge n stores `dq_i` as sampled at edge n+2.
- R3: Reads and writes may be issued on every edge in any order. A read issued one edge after a write to the same address returns the newly written lanes.
- R4: While `clk_en_n`=1, every input is ignored and all pipeline, burst and memory state holds. Outputs keep their values.
- R5: A load (`adv_ld`=0) starts an operation only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. A load without all three selects is a deselect and enters `ST_IDLE`.
- R6: A deselect does not cancel reads or writes already issued; they still complete.
- R7: `dq_oe` is 0 in the data phase of a write or a deselect, that is, two cycles after it was issued.
- R8: With `burst_ilv`=0, each advance issues the address whose low two bits are the load address low bits plus the burst count, modulo 4. The upper bits are unchanged.
- R9: With `burst_ilv`=1, the low two bits are the load address low bits XOR the burst count.
- R10: `byte_wr_n[i]`=0 enables a write to bits [9i+8:9i] of the word. It is sampled with the write data at edge n+2. Lanes whose bit is 1 keep their old contents.
- R11: `out_en_n`=1 forces `dq_oe` to 0 at once, without waiting for a clock edge.
- R12: While `rst_n`=0, `dq_oe` is 0 and the decoder is in `ST_IDLE`.
- R13: An advance ignores `rd_wr` and the chip selects. An advance in `ST_IDLE` issues nothing. The burst count wraps after four words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; 1 stalls the block |
| adv_ld | input | 1 | 0 = load a new command, 1 = advance the burst |
| rd_wr | input | 1 | 1 = read, 0 = write (sampled on loads) |
| addr | input | ADDR_W | Word address |
| ce_a_n | input | 1 | Chip select, active low |
| ce_b | input | 1 | Chip select, active high |
| ce_c_n | input | 1 | Chip select, active low |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| byte_wr_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | LANES*LANE_W | Data from the pad |
| dq_o | output | LANES*LANE_W | Data to the pad |
| dq_oe | output | 1 | Pad output enable |

## Verification
A decoder left in the wrong state shows up two edges later, as `dq_oe` high in a write data phase or low in a read data phase. A burst counter that steps wrongly shows up two edges later as a word taken from the wrong address. A missing write-to-read forward shows up on the very next read data phase as stale lanes on `dq_o`. A stall that leaks into the pipeline shifts every later data phase by a cycle, so the next compare fails. The bench compares `dq_oe` and `dq_o` with a behavioural model on every cycle, so each of these faults is reported within two or three cycles of its cause.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } state_e;

    localparam int BURST_W = 2;
endpackage

// File: rtl/zbt_cmd_fsm.sv
module zbt_cmd_fsm
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              adv,
    input  logic              rd_wr,
    input  logic              sel_ok,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr,
    output op_e               iss_op,
    output logic [ADDR_W-1:0] iss_addr
);
    localparam int HI_W = ADDR_W - BURST_W;

    state_e              state_q, state_d;
    logic [ADDR_W-1:0]   base_q, base_d;
    logic [BURST_W-1:0]  cnt_q, cnt_d;
    logic [BURST_W-1:0]  cnt_nx;
    logic [BURST_W-1:0]  low_nx;

    assign cnt_nx = cnt_q + 1'b1;
    // burst order: interleaved xors the count in, linear adds it modulo 4
    assign low_nx = burst_ilv ? (base_q[BURST_W-1:0] ^ cnt_nx)
                              : (base_q[BURST_W-1:0] + cnt_nx);

    // next-state process
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        if (!adv) begin
            if (sel_ok) begin
                state_d = rd_wr ? ST_READ : ST_WRITE;
                base_d  = addr;
                cnt_d   = '0;
            end else begin
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_IDLE:  cnt_d = cnt_q;
                ST_READ:  cnt_d = cnt_nx;
                ST_WRITE: cnt_d = cnt_nx;
                default:  cnt_d = cnt_q;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
        end else if (!stall) begin
            state_q <= state_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
        end
    end

    // output process: the command issued into the pipeline this cycle
    always_comb begin
        iss_op   = OP_NONE;
        iss_addr = base_q;
        if (!adv) begin
            if (sel_ok) begin
                iss_op   = rd_wr ? OP_READ : OP_WRITE;
                iss_addr = addr;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    iss_op   = OP_NONE;
                    iss_addr = base_q;
                end
                ST_READ: begin
                    iss_op   = OP_READ;
                    iss_addr = {base_q[ADDR_W-1 -: HI_W], low_nx};
                end
                ST_WRITE: begin
                    iss_op   = OP_WRITE;
                    iss_addr = {base_q[ADDR_W-1 -: HI_W], low_nx};
                end
                default: begin
                    iss_op   = OP_NONE;
                    iss_addr = base_q;
                end
            endcase
        end
    end

    p_desel_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !adv && !sel_ok) |=> (state_q == ST_IDLE));

    p_burst_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv && state_q != ST_IDLE) |=> (cnt_q == $past(cnt_q) + 2'd1));

    p_adv_keeps_state_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv) |=> (state_q == $past(state_q)));
endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  op_e               in_op,
    input  logic [ADDR_W-1:0] in_addr,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output op_e               s2_op,
    output logic [ADDR_W-1:0] s2_addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_op   <= OP_NONE;
            s1_addr <= '0;
            s2_op   <= OP_NONE;
            s2_addr <= '0;
        end else if (!stall) begin
            s1_op   <= in_op;
            s1_addr <= in_addr;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
        end
    end

    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(s1_op) && $stable(s2_op) && $stable(s1_addr) && $stable(s2_addr)));
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stall,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [LANES-1:0]        wr_be_n,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_q
);
    localparam int WORD_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] merged;
    logic              hit;

    assign rd_word = mem[rd_addr];
    assign hit     = wr_en && (wr_addr == rd_addr);

    // a read meeting a same-edge write sees the enabled new lanes
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = (hit && !wr_be_n[g])
                                          ? wr_data[g*LANE_W +: LANE_W]
                                          : rd_word[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (!stall && wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (!wr_be_n[i]) begin
                    mem[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (!stall && rd_en) begin
            rd_q <= merged;
        end
    end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    adv_ld,
    input  logic                    rd_wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce_a_n,
    input  logic                    ce_b,
    input  logic                    ce_c_n,
    input  logic                    burst_ilv,
    input  logic [LANES-1:0]        byte_wr_n,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] dq_i,
    output logic [LANES*LANE_W-1:0] dq_o,
    output logic                    dq_oe
);
    op_e               iss_op, s1_op, s2_op;
    logic [ADDR_W-1:0] iss_addr, s1_addr, s2_addr;
    logic              sel_ok;
    logic              drive_q;

    assign sel_ok = !ce_a_n && ce_b && !ce_c_n;

    zbt_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (clk_en_n),
        .adv      (adv_ld),
        .rd_wr    (rd_wr),
        .sel_ok   (sel_ok),
        .burst_ilv(burst_ilv),
        .addr     (addr),
        .iss_op   (iss_op),
        .iss_addr (iss_addr)
    );

    zbt_pipe #(.ADDR_W(ADDR_W)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (clk_en_n),
        .in_op  (iss_op),
        .in_addr(iss_addr),
        .s1_op  (s1_op),
        .s1_addr(s1_addr),
        .s2_op  (s2_op),
        .s2_addr(s2_addr)
    );

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (clk_en_n),
        .wr_en  (s2_op == OP_WRITE),
        .wr_addr(s2_addr),
        .wr_data(dq_i),
        .wr_be_n(byte_wr_n),
        .rd_en  (s1_op == OP_READ),
        .rd_addr(s1_addr),
        .rd_q   (dq_o)
    );

    // bus direction: drive only during a read data phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
        end else if (!clk_en_n) begin
            drive_q <= (s1_op == OP_READ);
        end
    end

    assign dq_oe = drive_q && !out_en_n;

    p_bus_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drive_q == (s2_op == OP_READ));
endmodule

// File: tb/zbt_sram_test.sv
module zbt_sram_test;
    localparam int PERIOD = 10;
    localparam int AW = 6;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int WW = LN * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          adv_ld = 1'b0;
    logic          rd_wr = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          ce_a_n = 1'b1;
    logic          ce_b = 1'b0;
    logic          ce_c_n = 1'b1;
    logic          burst_ilv = 1'b0;
    logic [LN-1:0] byte_wr_n = '0;
    logic          out_en_n = 1'b0;
    logic [WW-1:0] dq_i = '0;
    logic [WW-1:0] dq_o;
    logic          dq_oe;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R12";
    bit    done = 1'b0;
    bit    rnd_stall = 1'b0, rnd_be = 1'b0, rnd_oe = 1'b0;
    int    off_sel = 0;

    zbt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
        .rd_wr(rd_wr), .addr(addr), .ce_a_n(ce_a_n), .ce_b(ce_b),
        .ce_c_n(ce_c_n), .burst_ilv(burst_ilv), .byte_wr_n(byte_wr_n),
        .out_en_n(out_en_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    always #(PERIOD/2) clk = ~clk;

    // behavioural reference model: 0 idle, 1 read, 2 write
    int            m_state = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    int            p1_op = 0, p2_op = 0;
    logic [AW-1:0] p1_a = '0, p2_a = '0;
    bit            exp_drv = 1'b0;
    logic [WW-1:0] exp_data = '0;
    logic [WW-1:0] mem_m [1 << AW];

    initial for (int i = 0; i < (1 << AW); i++) mem_m[i] = '0;

    always @(posedge clk or negedge rst_n) begin
        int            iop;
        logic [AW-1:0] ia;
        logic [1:0]    lo;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; p1_op = 0; p2_op = 0; exp_drv = 0; exp_data = '0;
        end else if (!clk_en_n) begin
            iop = 0; ia = '0;
            if (!adv_ld) begin
                if (!ce_a_n && ce_b && !ce_c_n) begin
                    iop = rd_wr ? 1 : 2; ia = addr; m_base = addr; m_cnt = 0; m_state = iop;
                end else m_state = 0;
            end else if (m_state != 0) begin
                m_cnt = m_cnt + 2'd1;
                lo = burst_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
                iop = m_state; ia = {m_base[AW-1:2], lo};
            end
            if (p2_op == 2)
                for (int i = 0; i < LN; i++)
                    if (!byte_wr_n[i]) mem_m[p2_a][i*LW +: LW] = dq_i[i*LW +: LW];
            if (p1_op == 1) exp_data = mem_m[p1_a];
            exp_drv = (p1_op == 1);
            p2_op = p1_op; p2_a = p1_a;
            p1_op = iop;   p1_a = ia;
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (dq_oe !== (exp_drv && !out_en_n)) begin
                failures++;
                $display("FAIL %s dq_oe=%0b expected=%0b", cur_req, dq_oe, exp_drv && !out_en_n);
            end else if (dq_oe && dq_o !== exp_data) begin
                failures++;
                $display("FAIL %s dq_o=%h expected=%h", cur_req, dq_o, exp_data);
            end
        end
    end

    task automatic step(bit adv_i, bit rw_i, logic [AW-1:0] a, bit sel_i);
        adv_ld = adv_i; rd_wr = rw_i; addr = a;
        ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
        if (!sel_i) begin
            case (off_sel % 3)
                0: ce_a_n = 1'b1;
                1: ce_b = 1'b0;
                default: ce_c_n = 1'b1;
            endcase
            off_sel++;
        end
        dq_i = WW'({$urandom, $urandom});
        byte_wr_n = rnd_be ? LN'($urandom) : '0;
        out_en_n = rnd_oe ? 1'($urandom) : 1'b0;
        clk_en_n = rnd_stall ? ($urandom % 4 == 0) : 1'b0;
        @(posedge clk); #2;
    endtask

    task automatic rand_step();
        int k = $urandom % 4;
        case (k)
            0: step(1'b0, 1'b1, AW'($urandom), 1'b1);
            1: step(1'b0, 1'b0, AW'($urandom), 1'b1);
            2: step(1'b1, 1'($urandom), AW'($urandom), 1'($urandom));
            default: step(1'b0, 1'($urandom), AW'($urandom), 1'b0);
        endcase
    endtask

    task automatic burst(bit rw_i, logic [AW-1:0] a);
        step(1'b0, rw_i, a, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b1, ~rw_i, a, 1'b0);
    endtask

    initial begin
        // R12: outputs quiet while reset is held
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        cur_req = "R2";
        for (int i = 0; i < (1 << AW); i++) step(1'b0, 1'b0, AW'(i), 1'b1);
        cur_req = "R1";
        for (int i = 0; i < 16; i++) begin
            step(1'b0, 1'b1, AW'(i * 3), 1'b1);
            if (i % 4 == 0) step(1'b0, 1'b1, '0, 1'b0);
        end
        cur_req = "R3";
        for (int i = 0; i < 16; i++) begin
            step(1'b0, 1'b0, AW'(i), 1'b1);
            step(1'b0, 1'b1, AW'(i), 1'b1);
            step(1'b0, 1'b1, AW'(i + 1), 1'b1);
            step(1'b0, 1'b0, AW'(i + 2), 1'b1);
        end
        cur_req = "R8";
        burst_ilv = 1'b0;
        burst(1'b1, 6'd6); burst(1'b0, 6'd9); burst(1'b1, 6'd9); burst(1'b1, 6'd11);
        cur_req = "R9";
        burst_ilv = 1'b1;
        burst(1'b1, 6'd7); burst(1'b0, 6'd13); burst(1'b1, 6'd12); burst(1'b1, 6'd14);
        burst_ilv = 1'b0;
        cur_req = "R5";
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b0, AW'(20 + i), 1'b1);
            step(1'b0, 1'b1, AW'(20 + i), 1'b0);
            step(1'b0, 1'b0, AW'(21 + i), 1'b0);
        end
        cur_req = "R6";
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1, AW'(30 + i), 1'b1);
            step(1'b0, 1'b0, AW'(40 + i), 1'b1);
            step(1'b0, 1'b1, '0, 1'b0);
            step(1'b0, 1'b1, '0, 1'b0);
            step(1'b0, 1'b1, AW'(40 + i), 1'b1);
        end
        cur_req = "R7";
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b1, AW'(i), 1'b1);
            step(1'b0, 1'($urandom), AW'(i), 1'b0);
            step(1'b0, 1'b0, AW'(50 + i), 1'b1);
        end
        cur_req = "R13";
        step(1'b0, 1'b1, '0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, AW'(i), 1'b1);
        step(1'b0, 1'b1, 6'd33, 1'b1);
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, AW'(i), 1'($urandom));
        step(1'b0, 1'b0, 6'd45, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, AW'(i), 1'b0);
        burst(1'b1, 6'd45);
        cur_req = "R4";
        rnd_stall = 1'b1;
        repeat (300) rand_step();
        rnd_stall = 1'b0;
        cur_req = "R10";
        rnd_be = 1'b1;
        for (int i = 0; i < 60; i++) begin
            step(1'b0, 1'b0, AW'(i), 1'b1);
            step(1'b0, 1'b1, AW'(i), 1'b1);
            rand_step();
        end
        rnd_be = 1'b0;
        cur_req = "R11";
        rnd_oe = 1'b1;
        repeat (300) rand_step();
        cur_req = "R3";
        rnd_stall = 1'b1; rnd_be = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            burst_ilv = 1'($urandom);
            rand_step();
        end
        rnd_stall = 1'b0; rnd_oe = 1'b0;
        step(1'b0, 1'b1, '0, 1'b0);
        step(1'b0, 1'b1, '0, 1'b0);
        @(negedge clk); #1;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog %s expired", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule